// File: doc/BRIEF.md
# Processor bus cycle controller

This block is the bus-master side of a simple parallel processor bus. A core hands it one request at a time: an address, write data, a direction bit, a flag choosing the isolated I/O space instead of memory, and a flag asking for a burst. The controller then runs the bus cycle. It drives the address, enables the data driver when write data must be on the bus, and asserts exactly one of four strobes: memory read, memory write, I/O read or I/O write.

Every operation has a fixed base of three clocks. The first clock puts the address out and raises the strobe. The second clock drives write data for a write, or simply waits for a read. The third clock is the completion phase: it repeats while the device holds `bus_ready` low, and read data is captured on the edge where `bus_ready` is seen high. A memory read with the burst flag set chains four such operations at consecutive word addresses. A nonzero `wait_limit` ends a stalled operation with an error.

The core sees a plain handshake. `req_ready` is high only while the controller is idle. `rsp_ack` pulses once for every completed operation, and `rsp_last` marks the final one of a transaction.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `req_ready` is 1, all four strobes, `bus_oe` and `rsp_ack` are 0, and `bus_addr` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle that carries the final `rsp_ack`. A `req_valid` raised while the controller is busy is ignored. `rsp_ack` is never high in two consecutive cycles.
- R3: For a read taken at edge E0 with no wait states, the strobe is high in the three cycles after E0 and `bus_addr` holds the address. `bus_din` is sampled at the third edge after E0, and `rsp_ack` with that value on `rsp_data` is high in the following cycle.
- R4: A write uses the same three-clock strobe window. `bus_oe` is 0 in the first clock and 1 in the second and third, with `bus_dout` equal to the request's write data. `rsp_ack` follows in the cycle after the third clock.
- R5: Each edge in the third clock where `bus_ready` is 0 adds one more third-clock cycle. During that cycle the strobe, address and (for writes) `bus_oe` are held, and `rsp_ack` stays 0.
- R6: `req_io`=1 selects `io_rd` or `io_wr` and `req_io`=0 selects `mem_rd` or `mem_wr`. The strobes of the other space stay 0.
- R7: A memory read with `req_burst`=1 performs four operations at addresses A, A+W, A+2W and A+3W (modulo 2^AW), where W = DW/8 bytes. Each operation has its own three-clock timing and its own wait states. Each one gives one `rsp_ack`, and `rsp_last`=1 only on the fourth.
- R8: `req_burst` is ignored for writes and for I/O reads. Such a request performs one operation, and its `rsp_ack` carries `rsp_last`=1.
- R9: With `wait_limit`=N nonzero, an operation whose third clock sees `bus_ready` 0 at N consecutive edges ends at the Nth edge. The next cycle has `rsp_ack`=1, `rsp_err`=1, `rsp_last`=1, `rsp_data`=0 and all strobes low, and any remaining burst beats are dropped. `wait_limit`=0 never times out. The wait count restarts for every operation.
- R10: `bus_oe` is never 1 while `mem_rd` or `io_rd` is 1, and it is 0 in the first clock of every write. The data driver is therefore released for at least one clock before any read.
- R11: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = isolated I/O space, 0 = memory |
| req_burst | input | 1 | Four-word burst, honoured for memory reads only |
| wait_limit | input | TW | Wait-state limit before error, 0 = none |
| rsp_ack | output | 1 | One-clock completion pulse per operation |
| rsp_data | output | DW | Read data, valid with rsp_ack |
| rsp_err | output | 1 | Operation ended by timeout |
| rsp_last | output | 1 | Final operation of the transaction |
| bus_addr | output | AW | Bus address, 0 when idle |
| bus_dout | output | DW | Data toward the bus driver |
| bus_oe | output | 1 | Tri-state driver enable for bus_dout |
| bus_din | input | DW | Data seen on the bus |
| bus_ready | input | 1 | Device ready, active high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The bench builds the controller with AW=16, DW=16 and TW=4, so a word step is 2 bytes and limits up to 15 fit. The small counter width lets every limit from 1 to 3 be hit exactly and just missed, with the same wait counts as the untimed runs. It sweeps all four space and direction pairs against zero to three wait states, and varies per-beat waits inside bursts, including a burst that wraps past the top of the 16-bit space. A burst is also aborted on its second beat. Every cycle of every operation is compared with the cycle position worked out from the requirements.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_END  = 2'd3
  } phase_e;
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_burst,
  input  logic          bus_ready,
  input  logic [TW-1:0] wait_limit,
  output phase_e        phase,
  output logic          cmd_write,
  output logic          cmd_io,
  output logic          accept,
  output logic          beat_ok,
  output logic          beat_tmo,
  output logic          next_beat,
  output logic          final_beat
);
  localparam int BCW = (BEATS > 1) ? $clog2(BEATS) : 1;

  phase_e         phase_q, phase_d;
  logic           write_q, io_q, burst_q;
  logic [BCW-1:0] beat_q, beat_d;
  logic           beat_en;
  logic [TW-1:0]  wcnt_q, wcnt_d;
  logic           wcnt_en;
  logic           in_end;

  always_comb begin
    in_end     = (phase_q == PH_END);
    accept     = (phase_q == PH_IDLE) && req_valid;
    beat_ok    = in_end && bus_ready;
    beat_tmo   = in_end && !bus_ready && (wait_limit != '0) &&
                 ((wcnt_q + TW'(1)) == wait_limit);
    next_beat  = beat_ok && burst_q && (beat_q != BCW'(BEATS - 1));
    final_beat = beat_tmo || (beat_ok && !next_beat);
  end

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_DATA;
      PH_DATA: phase_d = PH_END;
      PH_END: begin
        if (next_beat)                phase_d = PH_ADDR;
        else if (beat_ok || beat_tmo) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    beat_en = accept || next_beat;
    beat_d  = accept ? '0 : beat_q + BCW'(1);
    wcnt_en = in_end;
    wcnt_d  = (beat_ok || beat_tmo) ? '0 : wcnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      io_q    <= 1'b0;
      burst_q <= 1'b0;
    end else if (accept) begin
      write_q <= req_write;
      io_q    <= req_io;
      burst_q <= req_burst && !req_write && !req_io;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  assign phase     = phase_q;
  assign cmd_write = write_q;
  assign cmd_io    = io_q;

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wait_limit != '0) && in_end) |-> (wcnt_q < wait_limit));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_end && !bus_ready && (wait_limit == '0)) |=> (phase_q == PH_END));
endmodule

// File: rtl/bcc_strb.sv
module bcc_strb
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   cmd_write,
  input  logic   cmd_io,
  output logic   mem_rd,
  output logic   mem_wr,
  output logic   io_rd,
  output logic   io_wr,
  output logic   bus_oe
);
  logic active;

  always_comb begin
    active = (phase != PH_IDLE);
    mem_rd = active && !cmd_write && !cmd_io;
    mem_wr = active &&  cmd_write && !cmd_io;
    io_rd  = active && !cmd_write &&  cmd_io;
    io_wr  = active &&  cmd_write &&  cmd_io;
    bus_oe = cmd_write && ((phase == PH_DATA) || (phase == PH_END));
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  // R10
  oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!mem_rd && !io_rd));

  // R4
  oe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr || io_wr) |-> !bus_oe);
endmodule

// File: rtl/bcc_dp.sv
module bcc_dp #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          next_beat,
  input  logic          beat_ok,
  input  logic          beat_tmo,
  input  logic          final_beat,
  input  logic          busy,
  input  logic          cmd_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last
);
  localparam int STEP = DW / 8;

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          beat_end;
  logic          ack_q, err_q, last_q;

  always_comb begin
    beat_end = beat_ok || beat_tmo;
    addr_en  = accept || next_beat;
    addr_d   = accept ? req_addr : addr_q + AW'(STEP);
    rdata_d  = (beat_ok && !cmd_write) ? bus_din : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (beat_end) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      ack_q  <= beat_end;
      err_q  <= beat_tmo;
      last_q <= final_beat;
    end
  end

  assign bus_addr = busy ? addr_q : '0;
  assign bus_dout = wdata_q;
  assign rsp_ack  = ack_q;
  assign rsp_data = rdata_q;
  assign rsp_err  = err_q;
  assign rsp_last = last_q;

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R5
  ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && !rsp_err) |-> $past(bus_ready));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 8,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_burst,
  input  logic [TW-1:0] wait_limit,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_last,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr
);
  phase_e phase;
  logic   cmd_write, cmd_io;
  logic   accept, beat_ok, beat_tmo, next_beat, final_beat;
  logic   busy;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;

  bcc_seq #(.BEATS(BEATS), .TW(TW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_burst(req_burst), .bus_ready(bus_ready), .wait_limit(wait_limit),
    .phase(phase), .cmd_write(cmd_write), .cmd_io(cmd_io),
    .accept(accept), .beat_ok(beat_ok), .beat_tmo(beat_tmo),
    .next_beat(next_beat), .final_beat(final_beat)
  );

  bcc_strb strb_i (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .cmd_write(cmd_write), .cmd_io(cmd_io),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .bus_oe(bus_oe)
  );

  bcc_dp #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .next_beat(next_beat), .beat_ok(beat_ok),
    .beat_tmo(beat_tmo), .final_beat(final_beat), .busy(busy),
    .cmd_write(cmd_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_din(bus_din), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_dout(bus_dout),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_last(rsp_last)
  );

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !(req_ready && rsp_ack && !rsp_last));

  // R9
  tmo_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && rsp_err) |-> (rsp_last && req_ready));
endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
module bus_cycle_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write, req_io, req_burst;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [TW-1:0] wait_limit;
  logic          rsp_ack, rsp_err, rsp_last;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_oe, bus_ready;
  logic          mem_rd, mem_wr, io_rd, io_wr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW), .DW(DW), .TW(TW), .BEATS(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .req_burst(req_burst), .wait_limit(wait_limit),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_last(rsp_last), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din), .bus_ready(bus_ready),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_strb(input bit wr, input bit io, input string tag);
    logic [3:0] exp, act;
    exp = {!wr && !io, wr && !io, !wr && io, wr && io};
    act = {mem_rd, mem_wr, io_rd, io_wr};
    chk(act == exp, {tag, " R6 R11 strobes"}, 32'(act), 32'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic txn(input bit wr, input bit io, input bit bst,
                     input logic [15:0] a, input logic [15:0] wd,
                     input int w0, input int w1, input int w2, input int w3,
                     input int lim);
    int wt[4];
    int nb;
    bit done;
    logic [15:0] ea, din, edat;
    bit tmo, fin;
    wt = '{w0, w1, w2, w3};
    nb = (bst && !wr && !io) ? 4 : 1;
    done = 0;
    @(negedge clk);
    wait_limit = TW'(lim);
    req_write = wr; req_io = io; req_burst = bst;
    req_addr = a; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 1);
    step();
    req_valid = 1'b0;
    for (int b = 0; b < nb && !done; b++) begin
      ea = a + 16'(b * 2);
      // first clock
      chk_strb(wr, io, "R3 R4 clk1");
      chk(bus_oe == 1'b0, "R10 oe low in clk1", 32'(bus_oe), 0);
      chk(bus_addr == ea, "R7 R3 address clk1", 32'(bus_addr), 32'(ea));
      chk(req_ready == 1'b0, "R2 busy", 32'(req_ready), 0);
      if (b == 0) begin
        req_valid = 1'b1;
        req_addr  = 16'hDEAD;
      end
      step();
      req_valid = 1'b0;
      // second clock
      chk_strb(wr, io, "R3 R4 clk2");
      chk(bus_oe == wr, "R4 oe clk2", 32'(bus_oe), 32'(wr));
      if (wr) chk(bus_dout == wd, "R4 write data", 32'(bus_dout), 32'(wd));
      chk(bus_addr == ea, "R2 address kept while busy", 32'(bus_addr), 32'(ea));
      chk(rsp_ack == 1'b0, "R3 no ack clk2", 32'(rsp_ack), 0);
      step();
      // third clock and wait states
      for (int k = 0; ; k++) begin
        bus_ready = (k == wt[b]);
        din = 16'h5A00 ^ ea ^ 16'(k);
        bus_din = din;
        chk_strb(wr, io, "R5 clk3");
        chk(bus_oe == wr, "R5 R4 oe clk3", 32'(bus_oe), 32'(wr));
        chk(bus_addr == ea, "R5 address held", 32'(bus_addr), 32'(ea));
        tmo = (lim != 0) && (k < wt[b]) && (k + 1 == lim);
        fin = (k == wt[b]) || tmo;
        edat = (tmo || wr) ? 16'h0 : din;
        step();
        bus_ready = 1'b0;
        if (fin) begin
          chk(rsp_ack == 1'b1, "R3 R5 ack after ready", 32'(rsp_ack), 1);
          chk(rsp_err == tmo, "R9 error flag", 32'(rsp_err), 32'(tmo));
          chk(rsp_last == (tmo || b == nb - 1),
              (bst && nb == 1) ? "R8 burst ignored last" : "R7 last flag",
              32'(rsp_last), 32'(tmo || b == nb - 1));
          if (!wr || tmo)
            chk(rsp_data == edat, "R3 R9 read data", 32'(rsp_data), 32'(edat));
          if (tmo) done = 1;
          break;
        end else begin
          chk(rsp_ack == 1'b0, "R5 no ack in wait", 32'(rsp_ack), 0);
        end
      end
    end
    chk({mem_rd, mem_wr, io_rd, io_wr} == 4'b0, "R9 R3 strobes dropped",
        32'({mem_rd, mem_wr, io_rd, io_wr}), 0);
    chk(req_ready == 1'b1, "R2 idle after final ack", 32'(req_ready), 1);
    step();
    chk(rsp_ack == 1'b0, "R2 ack single pulse", 32'(rsp_ack), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0; req_burst = 1'b0;
    req_addr = '0; req_wdata = '0; wait_limit = '0;
    bus_din = '0; bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
    chk({mem_rd, mem_wr, io_rd, io_wr, bus_oe, rsp_ack} == 6'b0,
        "R1 reset outputs", 32'({mem_rd, mem_wr, io_rd, io_wr, bus_oe, rsp_ack}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_addr == '0, "R1 address after reset", 32'(bus_addr), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);

    // single operations: every space and direction against 0..3 waits
    for (int io = 0; io < 2; io++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w < 4; w++)
          txn(wr[0], io[0], (wr[0] || io[0]) && w[0],
              16'h0100 + 16'(w * 16 + io * 4 + wr * 8),
              16'h1234 ^ 16'(w * 257), w, 0, 0, 0, 0);

    // bursts with varied per-beat waits, including address wrap
    txn(0, 0, 1, 16'h2000, 0, 0, 0, 0, 0, 0);
    txn(0, 0, 1, 16'h3010, 0, 1, 2, 0, 3, 0);
    txn(0, 0, 1, 16'hFFFC, 0, 3, 0, 2, 1, 0);
    txn(0, 0, 1, 16'h4000, 0, 2, 2, 2, 2, 3);

    // timeouts: exact limit, one below, burst aborted on second beat
    for (int lim = 1; lim < 4; lim++) begin
      txn(0, 0, 0, 16'h5000 + 16'(lim), 0, lim, 0, 0, 0, lim);
      txn(1, 1, 0, 16'h6000 + 16'(lim), 16'hBEEF, lim - 1, 0, 0, 0, lim);
      txn(1, 0, 0, 16'h6100 + 16'(lim), 16'hCAFE, lim + 1, 0, 0, 0, lim);
      txn(0, 0, 1, 16'h7000, 0, 0, lim, 0, 0, lim);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule